// File: doc/BRIEF.md
# Shared-Memory Low-Rate Accumulator Bank

This block keeps a large set of slow accumulator words in one single-port memory and lets many fast front-end counters take turns using it. Each front-end counter sends an overflow amount along with its channel index. The bank adds that amount to the channel's word through one read-add-write operation. That operation always takes the same number of clock cycles, and one adder is shared by every channel. The amount is added at the least significant bit of the stored word, which carries the same weight as the top bit of the fast counter that produced it.

At the end of an integration, a final-readout request starts a sweep over every word in ascending address order. For each word the bank streams out only its upper field, rounded at the first discarded bit and saturated at full scale, and then writes the word back as zero. Dump requests that arrive while the engine is working wait in a small queue. The sweep has priority over them. They stay queued until it is finished, so a readout never mixes two integrations.

The dump port is valid/ready: a request moves when both are high at a rising edge. The fast counters may not be able to stall, so a request offered while ready is low is dropped and latches a sticky error flag. The readout port is also valid/ready: the sweep holds each word on the output until it is taken, and it does not move on until then.

Top module: `lsacc_bank`

## Requirements
- R1: Each accepted dump adds its unsigned DUMP_W-bit value to the LSB of the addressed ACC_W-bit word, modulo 2^ACC_W. Successive dumps to one channel accumulate.
- R2: A read-add-write lasts exactly RMW_CYC cycles. A single dump accepted at rising edge e by an idle bank with an empty queue leaves `busy` high until edge e+RMW_CYC+1 and low after it.
- R3: `dump_ready` is high whenever the queue has a free entry, and a request is taken at an edge where `dump_valid` and `dump_ready` are both high. If `dump_valid` is high while `dump_ready` is low, the request is discarded and `dump_err` is set. Once set, `dump_err` stays high until reset.
- R4: A final-readout sweep emits exactly NUM_CH words, for addresses 0 up to NUM_CH-1 in that order. `out_last` is 1 on the last word and 0 on all the others.
- R5: Each readout word is bits [ACC_W-1:ACC_W-OUT_W] plus bit ACC_W-OUT_W-1 of the stored word. If that sum exceeds 2^OUT_W-1, the result is 2^OUT_W-1.
- R6: Each word reads as zero after its readout, so a second sweep with no dumps in between returns all zeros.
- R7: Dumps accepted during a sweep do not change that sweep's output. They are applied once the sweep has finished.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values and the sweep does not advance.
- R9: With `out_ready` held high, the first readout word is valid RMW_CYC+1 edges after the edge that samples `final_req` on an idle bank. Each later word follows RMW_CYC cycles after the one before.
- R10: During reset `out_valid` and `dump_err` are 0. After reset, an initial pass writes zero to all NUM_CH words, one word per cycle, with `busy` high, and `busy` falls NUM_CH cycles after reset is released.
- R11: `busy` is high while an operation runs, while a readout is pending, or while the queue holds requests. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump_valid | input | 1 | Dump request offered |
| dump_ready | output | 1 | Queue can take a request |
| dump_ch | input | CH_W | Channel index of the dump |
| dump_val | input | DUMP_W | Amount to add at the word LSB |
| final_req | input | 1 | One-cycle pulse that ends the integration and starts the sweep |
| out_valid | output | 1 | Readout word available |
| out_ready | input | 1 | Consumer takes the readout word |
| out_data | output | OUT_W | Rounded, saturated upper field of one word |
| out_last | output | 1 | Marks the word from the highest address |
| busy | output | 1 | Engine active, readout pending or queue not empty |
| dump_err | output | 1 | Sticky flag for a discarded request |

## Verification
A dump taken at edge e into an idle bank reaches the memory at edge e+RMW_CYC+1. At that same edge `busy` falls, so the bench counts falling clock edges from the acceptance and expects `busy` low on the (RMW_CYC+2)-th. The same counting gives the first readout word at the (RMW_CYC+2)-th falling edge after the request edge and RMW_CYC falling edges between later words. Data checks do not rely on fixed cycle positions: the bench waits for `out_valid` and compares in address order, so stalls from back-pressure or from a full queue do not shift what is expected. Rounding is covered for every possible stored value of a small configuration, including saturation and word wrap.

// File: rtl/lsacc_pkg.sv
package lsacc_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_DUMP  = 2'd2,
    ST_SWEEP = 2'd3
  } eng_state_t;
endpackage

// File: rtl/lsacc_fifo.sv
module lsacc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (PW+1)'(DEPTH));
endmodule

// File: rtl/lsacc_ram.sv
module lsacc_ram #(
  parameter int WORDS = 2048,
  parameter int W     = 15,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/lsacc_round.sv
module lsacc_round #(
  parameter int IN_W  = 15,
  parameter int OUT_W = 12
) (
  input  logic [IN_W-1:0]  word_i,
  output logic [OUT_W-1:0] rnd_o
);
  localparam int DROP = IN_W - OUT_W;

  generate
    if (DROP == 0) begin : g_pass
      assign rnd_o = word_i;
    end else begin : g_round
      logic [OUT_W-1:0] keep;
      logic             half;
      logic [OUT_W:0]   sum;
      assign keep  = word_i[IN_W-1 -: OUT_W];
      assign half  = word_i[DROP-1];
      assign sum   = {1'b0, keep} + {{OUT_W{1'b0}}, half};
      assign rnd_o = sum[OUT_W] ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lsacc_bank.sv
module lsacc_bank import lsacc_pkg::*; #(
  parameter int NUM_CH     = 2048,
  parameter int ACC_W      = 15,
  parameter int OUT_W      = 12,
  parameter int DUMP_W     = 4,
  parameter int RMW_CYC    = 4,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dump_valid,
  output logic              dump_ready,
  input  logic [CH_W-1:0]   dump_ch,
  input  logic [DUMP_W-1:0] dump_val,
  input  logic              final_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last,
  output logic              busy,
  output logic              dump_err
);
  localparam int CNT_W = (RMW_CYC > 1) ? $clog2(RMW_CYC) : 1;
  localparam int ENT_W = CH_W + DUMP_W;

  eng_state_t        state_q;
  logic [CH_W-1:0]   addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DUMP_W-1:0] add_q;
  logic              final_pend_q;

  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [ENT_W-1:0]  fifo_dout;
  logic              ram_we;
  logic [ACC_W-1:0]  ram_wdata, ram_rdata;
  logic [OUT_W-1:0]  rnd_word, rnd_keep;
  logic              last_addr, op_last, out_block, sweep_emit;

  assign dump_ready = !fifo_full;
  assign fifo_push  = dump_valid && !fifo_full;
  assign fifo_pop   = (state_q == ST_IDLE) && !final_pend_q && !fifo_empty;

  lsacc_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_i(fifo_push), .data_i({dump_ch, dump_val}),
    .pop_i(fifo_pop), .data_o(fifo_dout), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  assign last_addr  = (addr_q == CH_W'(NUM_CH-1));
  assign op_last    = (cnt_q == CNT_W'(RMW_CYC-1));
  assign out_block  = out_valid && !out_ready;
  assign sweep_emit = (state_q == ST_SWEEP) && op_last && !out_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_INIT;
      addr_q       <= '0;
      cnt_q        <= '0;
      add_q        <= '0;
      final_pend_q <= 1'b0;
    end else begin
      if (final_req && state_q != ST_SWEEP) final_pend_q <= 1'b1;
      case (state_q)
        ST_INIT: begin
          if (last_addr) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (final_pend_q) begin
            state_q      <= ST_SWEEP;
            addr_q       <= '0;
            cnt_q        <= '0;
            final_pend_q <= 1'b0;
          end else if (!fifo_empty) begin
            state_q <= ST_DUMP;
            addr_q  <= fifo_dout[ENT_W-1 -: CH_W];
            add_q   <= fifo_dout[DUMP_W-1:0];
            cnt_q   <= '0;
          end
        end
        ST_DUMP: begin
          if (op_last) state_q <= ST_IDLE;
          else         cnt_q   <= cnt_q + 1'b1;
        end
        default: begin
          if (!op_last) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (!out_block) begin
            if (last_addr) begin
              state_q <= ST_IDLE;
            end else begin
              addr_q <= addr_q + 1'b1;
              cnt_q  <= '0;
            end
          end
        end
      endcase
    end
  end

  assign ram_we    = (state_q == ST_INIT) || ((state_q == ST_DUMP) && op_last) || sweep_emit;
  assign ram_wdata = (state_q == ST_DUMP) ? ram_rdata + ACC_W'(add_q) : '0;

  lsacc_ram #(.WORDS(NUM_CH), .W(ACC_W), .AW(CH_W)) u_mem (
    .clk(clk), .we_i(ram_we), .addr_i(addr_q), .wdata_i(ram_wdata), .rdata_o(ram_rdata)
  );

  lsacc_round #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_round (
    .word_i(ram_rdata), .rnd_o(rnd_word)
  );
  assign rnd_keep = ram_rdata[ACC_W-1 -: OUT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (sweep_emit) begin
      out_valid <= 1'b1;
      out_data  <= rnd_word;
      out_last  <= last_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        dump_err <= 1'b0;
    else if (dump_valid && fifo_full) dump_err <= 1'b1;
  end

  assign busy = (state_q != ST_IDLE) || final_pend_q || !fifo_empty;

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R7
  sweep_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SWEEP |=> state_q != ST_DUMP);
  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_err |=> dump_err);
  // R11
  busy_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |=> busy);
  // R4
  emit_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state_q) == ST_SWEEP);
  // R5
  rnd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_emit |=> out_data >= $past(rnd_keep));
endmodule

// File: tb/test_lsacc_bank.sv
`timescale 1ns/1ps
module test_lsacc_bank;
  localparam int N  = 8;
  localparam int AW = 6;
  localparam int OW = 3;
  localparam int DW = 3;
  localparam int RC = 3;
  localparam int FD = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          dump_valid, dump_ready;
  logic [CW-1:0] dump_ch;
  logic [DW-1:0] dump_val;
  logic          final_req;
  logic          out_valid, out_ready, out_last;
  logic [OW-1:0] out_data;
  logic          busy, dump_err;

  lsacc_bank #(.NUM_CH(N), .ACC_W(AW), .OUT_W(OW), .DUMP_W(DW),
               .RMW_CYC(RC), .FIFO_DEPTH(FD)) i_lsacc_bank (
    .clk(clk), .rst_n(rst_n), .dump_valid(dump_valid), .dump_ready(dump_ready),
    .dump_ch(dump_ch), .dump_val(dump_val), .final_req(final_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .busy(busy), .dump_err(dump_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rexp(input int v);
    int w, t;
    w = v % (1 << AW);
    t = (w >> (AW - OW)) + ((w >> (AW - OW - 1)) & 1);
    if (t > (1 << OW) - 1) t = (1 << OW) - 1;
    return t;
  endfunction

  task automatic dump(input int ch, input int val);
    forever begin
      @(negedge clk);
      if (dump_ready) begin
        dump_valid = 1'b1;
        dump_ch    = CW'(ch);
        dump_val   = DW'(val);
        @(negedge clk);
        dump_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic fire_final();
    @(negedge clk);
    final_req = 1'b1;
    @(negedge clk);
    final_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic collect(input int exp_v[N], input int bp);
    for (int k = 0; k < N; k++) begin
      do @(negedge clk); while (!out_valid);
      if (k == bp) begin
        int d0;
        out_ready = 1'b0;
        d0 = int'(out_data);
        for (int j = 0; j < 4; j++) begin
          @(negedge clk);
          chk("R8 valid held", int'(out_valid), 1);
          chk("R8 data stable", int'(out_data), d0);
        end
        out_ready = 1'b1;
      end
      chk("R1 R5 word", int'(out_data), exp_v[k]);
      chk("R4 last flag", int'(out_last), (k == N - 1) ? 1 : 0);
    end
  endtask

  initial begin
    int ev[N];
    int n, acc, saw_low;
    rst_n = 1'b0; dump_valid = 1'b0; dump_ch = '0; dump_val = '0;
    final_req = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", int'(out_valid), 0);
    chk("R10 dump_err in reset", int'(dump_err), 0);
    rst_n = 1'b1;
    chk("R10 busy at init", int'(busy), 1);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    chk("R10 init length", n, N);

    // Exhaustive stored values 0..63, then wrapped values.
    for (int it = 0; it < 9; it++) begin
      for (int c = 0; c < N; c++) begin
        int v, rem;
        v = (it < 8) ? it * N + c : 70 + c;
        ev[c] = rexp(v);
        rem = v;
        while (rem > 0) begin
          int d;
          d = (rem > 7) ? 7 : rem;
          dump(c, d);
          rem -= d;
        end
      end
      wait_idle();
      fire_final();
      collect(ev, (it == 3) ? 2 : -1);
      wait_idle();
    end

    // R6: second sweep without dumps returns zeros.
    for (int c = 0; c < N; c++) ev[c] = 0;
    fire_final();
    collect(ev, -1);
    wait_idle();
    chk("R6 sweep done", int'(busy), 0);

    // R7: dump during a sweep is held back.
    for (int c = 0; c < N; c++) ev[c] = 0;
    for (int j = 0; j < 5; j++) dump(3, 7);
    dump(3, 5);
    ev[3] = rexp(40);
    wait_idle();
    fire_final();
    dump(3, 5);
    collect(ev, -1);
    wait_idle();
    for (int c = 0; c < N; c++) ev[c] = 0;
    ev[3] = rexp(5);
    fire_final();
    collect(ev, -1);
    wait_idle();
    chk("R7 no error", int'(dump_err), 0);

    // R2: single dump latency on an idle bank.
    dump(2, 4);
    chk("R2 busy after accept", int'(busy), 1);
    n = 1;
    while (busy) begin @(negedge clk); n++; end
    chk("R2 RMW length", n, RC + 2);

    // R9: readout timing with ready high.
    fire_final();
    n = 1;
    while (!out_valid) begin @(negedge clk); n++; end
    chk("R9 first word latency", n, RC + 2);
    chk("R9 word 0", int'(out_data), 0);
    for (int k = 1; k < N; k++) begin
      int m;
      m = 0;
      do begin @(negedge clk); m++; end while (!out_valid);
      chk("R9 word spacing", m, RC);
      chk("R9 R4 word", int'(out_data), (k == 2) ? rexp(4) : 0);
    end
    wait_idle();

    // R3: overflow of the queue.
    chk("R3 no error yet", int'(dump_err), 0);
    acc = 0;
    saw_low = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      dump_valid = 1'b1; dump_ch = CW'(1); dump_val = DW'(1);
      if (dump_ready) acc++;
      else saw_low = 1;
    end
    @(negedge clk);
    dump_valid = 1'b0;
    chk("R3 ready dropped when full", saw_low, 1);
    chk("R3 error set", int'(dump_err), 1);
    wait_idle();
    chk("R3 error sticky", int'(dump_err), 1);
    for (int c = 0; c < N; c++) ev[c] = 0;
    ev[1] = rexp(acc);
    fire_final();
    collect(ev, -1);
    wait_idle();
    chk("R11 busy low when idle", int'(busy), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule